// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a simple in-order core and chooses, each cycle, the address of the following instruction. It looks at the instruction word now being executed and at the two register operands already read for it. From these it picks one of four candidates: the sequential address (PC+4), a PC-relative conditional branch target, a pseudo-direct jump target, or a register-indirect target. The chosen value is shown combinationally on `next_pc` and is loaded into the PC register on the next rising clock edge.

For the call instruction, the unit also raises a link write strobe and presents the return address PC+4. The register file writes that value into register 31. Exactly one instruction is consumed every clock, so there is no handshake and no back-pressure. The instruction and operand inputs must be stable before each rising edge.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets `pc` to 0.
- R2: An instruction whose 6-bit opcode (bits 31:26) is not 0, 2, 3, 4 or 5 gives `next_pc` = `pc` + 4.
- R3: Opcode 4 (branch-if-equal) with `rs_val` == `rt_val` gives `next_pc` = `pc` + 4 + 4 × offset, where the offset is bits 15:0.
- R4: Opcode 5 (branch-if-not-equal) with `rs_val` != `rt_val` gives the same branch target as R3.
- R5: A branch whose condition is false gives `next_pc` = `pc` + 4.
- R6: The 16-bit branch offset is sign-extended before it is scaled by 4, so offsets with bit 15 set branch backwards.
- R7: Opcode 2 (jump) gives `next_pc` = {bits 31:28 of `pc`+4, instruction bits 25:0, 2'b00}.
- R8: Opcode 3 (jump-and-link) jumps to the same target as R7. It also drives `link_we` high with `link_val` = `pc` + 4. `link_we` is low for every other instruction.
- R9: Opcode 0 with function field (bits 5:0) equal to 8 (jump-register) gives `next_pc` = `rs_val`.
- R10: Outside reset, `pc` takes the value that `next_pc` showed just before each rising edge.
- R11: With a word-aligned `pc`, every target except the jump-register one has its two low bits at 00.
- R12: Opcode 0 with any function value other than 8 advances sequentially, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word executed in the current cycle |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address chosen for the following cycle |
| link_val | output | 32 | Return address (pc + 4) |
| link_we | output | 1 | Request to write `link_val` into register 31 |

## Verification
`next_pc`, `link_val` and `link_we` depend combinationally on `pc` and the current inputs. They are due in the same cycle the stimulus is applied, and the bench samples them one time unit after it drives a new instruction on the falling edge. `pc` takes that choice one rising edge later. The bench's behavioural model advances its own PC at that edge and compares `pc` on the next falling edge, before applying the next instruction. Reset is checked one edge after `rst` is asserted, both at start-up and in the middle of a run.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;
  localparam int unsigned ALIGN_W = 2;
  localparam int unsigned HI_W    = XLEN - TGT_W - ALIGN_W;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BRNE    = 6'd5;
  localparam logic [FN_W-1:0]  FN_JREG     = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JMP,
    FLOW_CALL,
    FLOW_JREG
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  instr,
  output flow_e            flow,
  output logic [IMM_W-1:0] offset,
  output logic [TGT_W-1:0] target
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;

  assign opc    = instr[XLEN-1 -: OPC_W];
  assign fn     = instr[FN_W-1:0];
  assign offset = instr[IMM_W-1:0];
  assign target = instr[TGT_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_SPECIAL: flow = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
      OPC_JMP:     flow = FLOW_JMP;
      OPC_CALL:    flow = FLOW_CALL;
      OPC_BREQ:    flow = FLOW_BREQ;
      OPC_BRNE:    flow = FLOW_BRNE;
      default:     flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] offset,
  input  logic [TGT_W-1:0] target,
  output logic [XLEN-1:0]  seq_addr,
  output logic [XLEN-1:0]  br_addr,
  output logic [XLEN-1:0]  jmp_addr
);
  localparam int unsigned EXT_W = XLEN - IMM_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_W;

  logic [XLEN-1:0] disp;

  assign seq_addr = pc + STEP;
  assign disp     = {{EXT_W{offset[IMM_W-1]}}, offset, {ALIGN_W{1'b0}}};
  assign br_addr  = seq_addr + disp;
  assign jmp_addr = {seq_addr[XLEN-1 -: HI_W], target, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  flow_e           flow,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] br_addr,
  input  logic [XLEN-1:0] jmp_addr,
  output logic [XLEN-1:0] chosen,
  output logic            link_req
);
  logic same;

  assign same     = (rs_val == rt_val);
  assign link_req = (flow == FLOW_CALL);

  always_comb begin
    unique case (flow)
      FLOW_BREQ: chosen = same  ? br_addr : seq_addr;
      FLOW_BRNE: chosen = !same ? br_addr : seq_addr;
      FLOW_JMP,
      FLOW_CALL: chosen = jmp_addr;
      FLOW_JREG: chosen = rs_val;
      default:   chosen = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic [31:0] link_val,
  output logic        link_we
);
  flow_e            flow;
  logic [IMM_W-1:0] offset;
  logic [TGT_W-1:0] target;
  logic [XLEN-1:0]  seq_addr, br_addr, jmp_addr;

  npc_decode u_dec (
    .instr  (instr),
    .flow   (flow),
    .offset (offset),
    .target (target)
  );

  npc_targets u_tgt (
    .pc       (pc),
    .offset   (offset),
    .target   (target),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  npc_select u_sel (
    .flow     (flow),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr),
    .chosen   (next_pc),
    .link_req (link_we)
  );

  assign link_val = seq_addr;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic [31:0] link_val,
  input logic        link_we
);
  logic [5:0] opc;
  logic       is_jreg;
  assign opc     = instr[31:26];
  assign is_jreg = (opc == 6'd0) && (instr[5:0] == 6'd8);

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == 32'h0);

  // R10
  pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(next_pc));

  // R11
  target_align_chk: assert property (@(posedge clk) disable iff (rst)
    (pc[1:0] == 2'b00 && !is_jreg) |-> next_pc[1:0] == 2'b00);

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_val - pc) == 32'd4);

  // R8
  link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> opc == 6'd3);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (opc > 6'd5 || opc == 6'd1) |-> (next_pc - pc) == 32'd4);
endmodule

bind npc_unit npc_unit_chk i_npc_unit_chk (.*);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] pc, next_pc, link_val;
  logic        link_we;

  int checks = 0;
  int failures = 0;
  logic [31:0] model_pc = 32'h0;
  bit done = 0;

  always #10 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .next_pc(next_pc), .link_val(link_val), .link_we(link_we)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] cur, input logic [31:0] ins,
                                           input logic [31:0] a, input logic [31:0] b);
    int unsigned op = ins[31:26];
    longint off = longint'($signed(ins[15:0]));
    logic [31:0] after = cur + 32'd4;
    logic [31:0] far = (after & 32'hF000_0000) | ({6'd0, ins[25:0]} * 32'd4);
    if (op == 4 && a == b) return after + 32'(off * 4);
    if (op == 5 && a != b) return after + 32'(off * 4);
    if (op == 2 || op == 3) return far;
    if (op == 0 && ins[5:0] == 6'd8) return a;
    return after;
  endfunction

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [31:0] ins,
                      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    instr = ins; rs_val = a; rt_val = b;
    #1;
    exp = ref_next(model_pc, ins, a, b);
    check32(req, "pc", pc, model_pc);
    check32(req, "next_pc", next_pc, exp);
    check32("R8", "link_we", {31'd0, link_we}, {31'd0, ins[31:26] == 6'd3});
    if (ins[31:26] == 6'd3) check32("R8", "link_val", link_val, model_pc + 32'd4);
    @(posedge clk);
    model_pc = exp;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_br(input int op, input logic [15:0] off);
    return {6'(op), 5'd1, 5'd2, off};
  endfunction

  function automatic logic [31:0] mk_j(input int op, input logic [25:0] t);
    return {6'(op), t};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check32("R1", "pc after reset", pc, 32'h0);
    rst = 1'b0;
    model_pc = 32'h0;
    step("R12", 32'h0022_0820, 32'h5, 32'h6);          // funct 32, sequential
    step("R2",  32'h0000_0000, 32'h0, 32'h0);
    step("R3",  mk_br(4, 16'd3), 32'h77, 32'h77);        // beq taken
    step("R5",  mk_br(4, 16'd3), 32'h77, 32'h78);        // beq not taken
    step("R6",  mk_br(5, 16'hFFFE), 32'h1, 32'h2);       // bne taken backward (R4)
    step("R5",  mk_br(5, 16'h0040), 32'h9, 32'h9);       // bne not taken
    step("R7",  mk_j(2, 26'h100), 32'h0, 32'h0);
    step("R9",  32'h0200_0008, 32'hF000_0010, 32'h0);    // jr
    step("R8",  mk_j(3, 26'h20), 32'h0, 32'h0);          // jal
    step("R9",  32'h0200_0008, 32'h0FFF_FFFC, 32'h0);
    step("R7",  mk_j(2, 26'h5), 32'h0, 32'h0);           // upper bits from pc+4
    step("R2",  32'h8C22_0004, 32'h0, 32'h0);            // load-like opcode
    step("R4",  mk_br(5, 16'h7FFF), 32'h3, 32'h4);
    step("R6",  mk_br(4, 16'h8000), 32'h3, 32'h3);
    step("R11", mk_br(4, 16'h0001), 32'h0, 32'h0);
    check32("R11", "low bits", pc & 32'h3, 32'h0);
    step("R10", 32'h2000_0000, 32'h0, 32'h0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check32("R1", "pc after mid reset", pc, 32'h0);
    rst = 1'b0;
    model_pc = 32'h0;
    step("R3",  mk_br(4, 16'h0010), 32'h0, 32'h0);
    step("R2",  32'hFC00_0000, 32'h0, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule